// File: doc/BRIEF.md
# Receive Idle Timeout Timer

This block watches an asynchronous serial receive channel for inactivity. Software programs a 16-bit timeout period, split into a low byte and a high byte, and an 8-bit tick period for a prescaler. The prescaler divides the system clock into count ticks. An internal down-counter is loaded from the timeout period whenever the receiver pushes a character into the receive FIFO, or when the host pops the last entry out of that FIFO. The counter loses one count per prescaler tick. When it runs out, the block raises a receive-data interrupt request, which tells the host to collect a partial FIFO load.

The receiver, the FIFO and the interrupt controller are outside the block. It sees them only as single-cycle strobes and one status level. The timer works only while the channel is in asynchronous mode. The register bus writes one byte per strobe and reads back through a combinational mux.

Top module: `rxto_timer`

## Requirements
- R1: Register map: address 0 holds bits 7:0 of the timeout period, address 1 holds bits 15:8, and address 2 holds the 8-bit tick period. Address 3 reads as zero. All three registers reset to zero, and each reads back on `reg_rdata` in the same cycle its address is presented.
- R2: While `async_mode` is low, the timer does not count, reload strobes are ignored, and no interrupt is raised. Any pending interrupt is cleared one cycle after `async_mode` falls.
- R3: A `rx_push` strobe loads the down-counter with the 16-bit timeout period.
- R4: A `host_pop` strobe reloads the down-counter only when `fifo_one_left` is high in the same cycle. A pop at any other FIFO level has no effect on the countdown.
- R5: With tick period P, the prescaler ticks once every P+1 clocks, and P = 0 gives a tick on every clock. While `async_mode` is low the prescaler is held at P, so the first tick comes in the (P+1)-th cycle of asynchronous mode.
- R6: The counter loses one count per tick. `rx_irq` rises on the clock edge of the N-th tick after a reload with period N.
- R7: `rx_irq` stays high until an `irq_ack` strobe. After expiry it is not raised again until a new reload and a new full countdown.
- R8: When a reload and a tick fall in the same cycle, the reload wins and that tick is lost.
- R9: A timeout period of zero leaves the timer disarmed, so no interrupt follows the reload.
- R10: Writing a period byte during a countdown does not change that countdown. The new value is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| async_mode | input | 1 | Channel is in asynchronous mode |
| rx_push | input | 1 | A received character entered the FIFO |
| host_pop | input | 1 | The host read one FIFO entry |
| fifo_one_left | input | 1 | The FIFO holds exactly one entry |
| irq_ack | input | 1 | Host acknowledge, clears the interrupt |
| rx_irq | output | 1 | Receive-data timeout interrupt request |

## Verification
The assertions assume that the strobes are single-cycle pulses from a synchronous source. They also assume that `fifo_one_left` reflects the FIFO level in the same cycle as the pop it qualifies, and that a write and its address are valid together. The bench drives every input on the falling edge, raises each strobe for exactly one cycle, and changes `async_mode` only between scenarios. For timing checks it aligns the prescaler phase by entering asynchronous mode in the same cycle as the push. The block has no data stream, so there is no back-pressure to respect.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic {
    CT_IDLE = 1'b0,
    CT_RUN  = 1'b1
  } ct_state_e;

  function automatic logic reload_event(input logic mode_ok, input logic push,
                                        input logic pop, input logic last_one);
    return mode_ok && (push || (pop && last_one));
  endfunction
endpackage

// File: rtl/rxto_regs.sv
module rxto_regs #(
  parameter int PERIOD_W = 16,
  parameter int TICK_W   = 8,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [BYTE_W-1:0]   rdata,
  output logic [PERIOD_W-1:0] period,
  output logic [TICK_W-1:0]   tick_period
);
  localparam int NBYTES    = PERIOD_W / BYTE_W;
  localparam int TICK_ADDR = NBYTES;

  logic [PERIOD_W-1:0] period_q;
  logic [TICK_W-1:0]   tick_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        period_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (wr && addr == ADDR_W'(b))
        period_q[b*BYTE_W +: BYTE_W] <= wdata;
    end

    a_r1_byte_write : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_W'(b)) |=> period_q[b*BYTE_W +: BYTE_W] == $past(wdata));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      tick_q <= '0;
    else if (wr && addr == ADDR_W'(TICK_ADDR))
      tick_q <= wdata[TICK_W-1:0];
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBYTES; b++)
      if (addr == ADDR_W'(b)) rdata = period_q[b*BYTE_W +: BYTE_W];
    if (addr == ADDR_W'(TICK_ADDR)) rdata[TICK_W-1:0] = tick_q;
  end

  assign period      = period_q;
  assign tick_period = tick_q;

  a_r1_tick_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == ADDR_W'(TICK_ADDR)) |=> $stable(tick_q));
endmodule

// File: rtl/rxto_prescaler.sv
module rxto_prescaler #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [TICK_W-1:0] tick_period,
  output logic              tick
);
  logic [TICK_W-1:0] cnt_q;

  assign tick = enable && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!enable || tick)
      cnt_q <= tick_period;
    else
      cnt_q <= cnt_q - TICK_W'(1);
  end

  a_r5_tick_spacing : assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tick_period != '0) |=> !tick);
  a_r2_quiet_off : assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == $past(tick_period)));
endmodule

// File: rtl/rxto_counter.sv
module rxto_counter
  import rxto_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                reload,
  input  logic                tick,
  input  logic                ack,
  input  logic [PERIOD_W-1:0] period,
  output logic                irq
);
  ct_state_e           state_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic                irq_q;
  logic                expire;

  assign expire = (state_q == CT_RUN) && tick && !reload && (cnt_q == PERIOD_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state_q <= CT_IDLE;
      cnt_q   <= '0;
    end else if (reload) begin
      cnt_q   <= period;
      state_q <= (period == '0) ? CT_IDLE : CT_RUN;
    end else if (state_q == CT_RUN && tick) begin
      cnt_q <= cnt_q - PERIOD_W'(1);
      if (cnt_q == PERIOD_W'(1)) state_q <= CT_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !enable)
      irq_q <= 1'b0;
    else if (expire)
      irq_q <= 1'b1;
    else if (ack)
      irq_q <= 1'b0;
  end

  assign irq = irq_q;

  a_r2_no_irq_off : assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !irq_q);
  a_r7_irq_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !ack && enable) |=> irq_q);
  a_r7_no_reraise : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CT_IDLE && !reload) |=> !$rose(irq_q));
  a_r9_zero_disarms : assert property (@(posedge clk) disable iff (!rst_n)
    (enable && reload && period == '0) |=> state_q == CT_IDLE);
  a_r8_reload_wins : assert property (@(posedge clk) disable iff (!rst_n)
    (enable && reload && tick) |=> cnt_q == $past(period));
endmodule

// File: rtl/rxto_timer.sv
module rxto_timer
  import rxto_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int TICK_W   = 8,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              async_mode,
  input  logic              rx_push,
  input  logic              host_pop,
  input  logic              fifo_one_left,
  input  logic              irq_ack,
  output logic              rx_irq
);
  logic [PERIOD_W-1:0] period;
  logic [TICK_W-1:0]   tick_period;
  logic                tick;
  logic                reload;

  assign reload = reload_event(async_mode, rx_push, host_pop, fifo_one_left);

  rxto_regs #(
    .PERIOD_W(PERIOD_W), .TICK_W(TICK_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .period     (period),
    .tick_period(tick_period)
  );

  rxto_prescaler #(.TICK_W(TICK_W)) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (async_mode),
    .tick_period(tick_period),
    .tick       (tick)
  );

  rxto_counter #(.PERIOD_W(PERIOD_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(async_mode),
    .reload(reload),
    .tick  (tick),
    .ack   (irq_ack),
    .period(period),
    .irq   (rx_irq)
  );

  a_r4_pop_gated : assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && !fifo_one_left && !rx_push) |-> !reload);
endmodule

// File: tb/tb_rxto_timer.sv
module tb_rxto_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       async_mode = 1'b0;
  logic       rx_push = 1'b0;
  logic       host_pop = 1'b0;
  logic       fifo_one_left = 1'b0;
  logic       irq_ack = 1'b0;
  logic       rx_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rxto_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .async_mode(async_mode),
    .rx_push(rx_push), .host_pop(host_pop), .fifo_one_left(fifo_one_left),
    .irq_ack(irq_ack), .rx_irq(rx_irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic set_period(input int n);
    wr(2'd0, n[7:0]);
    wr(2'd1, n[15:8]);
  endtask

  task automatic pulse_push();
    rx_push = 1'b1; step(); rx_push = 1'b0;
  endtask

  task automatic clear_irq();
    irq_ack = 1'b1; step(); irq_ack = 1'b0;
  endtask

  // Leaves async off, enters async together with a push (aligned phase).
  task automatic start_aligned();
    async_mode = 1'b0; step();
    async_mode = 1'b1; rx_push = 1'b1; step(); rx_push = 1'b0;
  endtask

  // After a reload edge, irq must stay low for edges 1..last-1 and be high after edge last.
  task automatic expect_expiry(input int last, input string req);
    for (int e = 1; e < last; e++) begin
      step();
      check(rx_irq == 1'b0, req, rx_irq, 0);
    end
    step();
    check(rx_irq == 1'b1, req, rx_irq, 1);
  endtask

  task automatic t_reset();
    check(rx_irq == 1'b0, "R1 reset irq", rx_irq, 0);
    for (int a = 0; a < 4; a++) begin
      reg_addr = a[1:0]; #1;
      check(reg_rdata == 8'h00, "R1 reset value", reg_rdata, 0);
    end
  endtask

  task automatic t_regs();
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'h7E); wr(2'd3, 8'hFF);
    reg_addr = 2'd0; #1; check(reg_rdata == 8'hA5, "R1 low byte", reg_rdata, 8'hA5);
    reg_addr = 2'd1; #1; check(reg_rdata == 8'h3C, "R1 high byte", reg_rdata, 8'h3C);
    reg_addr = 2'd2; #1; check(reg_rdata == 8'h7E, "R1 tick period", reg_rdata, 8'h7E);
    reg_addr = 2'd3; #1; check(reg_rdata == 8'h00, "R1 unused address", reg_rdata, 0);
  endtask

  task automatic t_basic();
    wr(2'd2, 8'd0); set_period(5);
    start_aligned();
    expect_expiry(5, "R3 R6 push then five ticks");
    clear_irq();
    check(rx_irq == 1'b0, "R7 ack clears", rx_irq, 0);
  endtask

  task automatic t_prescaler();
    wr(2'd2, 8'd2); set_period(3);
    start_aligned();
    expect_expiry(2 + 2 * 3, "R5 three ticks at period 2");
    clear_irq();
    wr(2'd2, 8'd0);
  endtask

  task automatic t_pop();
    set_period(6);
    start_aligned();
    step(3);
    host_pop = 1'b1; fifo_one_left = 1'b0; step(); host_pop = 1'b0;
    // pop with several entries left: no reload, expiry stays at edge 6
    expect_expiry(2, "R4 non-last pop ignored");
    clear_irq();
    pulse_push();
    step(3);
    host_pop = 1'b1; fifo_one_left = 1'b1; step(); host_pop = 1'b0; fifo_one_left = 1'b0;
    expect_expiry(6, "R4 last-entry pop reloads");
    clear_irq();
  endtask

  task automatic t_restart();
    set_period(4);
    start_aligned();
    step(2);
    // tick every cycle, so this push also coincides with a tick: reload wins
    pulse_push();
    expect_expiry(4, "R8 reload beats tick");
  endtask

  task automatic t_sticky();
    step(20);
    check(rx_irq == 1'b1, "R7 irq held without ack", rx_irq, 1);
    clear_irq();
    step(30);
    check(rx_irq == 1'b0, "R7 no re-raise after expiry", rx_irq, 0);
  endtask

  task automatic t_zero();
    set_period(0);
    start_aligned();
    step(40);
    check(rx_irq == 1'b0, "R9 zero period disarmed", rx_irq, 0);
  endtask

  task automatic t_off();
    set_period(3);
    async_mode = 1'b0; step();
    pulse_push(); step(20);
    check(rx_irq == 1'b0, "R2 no irq out of async", rx_irq, 0);
    start_aligned();
    step(1);
    async_mode = 1'b0; step(1);
    async_mode = 1'b1; step(10);
    check(rx_irq == 1'b0, "R2 countdown dropped on mode exit", rx_irq, 0);
    start_aligned();
    expect_expiry(3, "R2 runs again in async");
    async_mode = 1'b0; step();
    check(rx_irq == 1'b0, "R2 irq cleared on mode exit", rx_irq, 0);
  endtask

  task automatic t_midwrite();
    set_period(5);
    start_aligned();
    wr(2'd0, 8'd40);
    expect_expiry(4, "R10 write mid-count ignored");
    clear_irq();
    pulse_push();
    expect_expiry(40, "R10 new value at next reload");
    clear_irq();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_regs();
    t_basic();
    t_prescaler();
    t_pop();
    t_restart();
    t_sticky();
    t_zero();
    t_off();
    t_midwrite();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule